// File: doc/BRIEF.md
# Storage Channel Interrupt Aggregator

This block collects the two interrupt causes of a single storage channel, the attached drive's interrupt and a memory-bus error seen by the channel's DMA engine. It holds them in a status register and combines them into one level-sensitive interrupt line for the host. Each cause is latched on a single-cycle event pulse and stays set until software clears it. Only the causes that software has enabled can drive the interrupt line.

Software reaches the block through a simple word-addressed register port. Reading one word returns the pending causes. A second word accepts a write-one-to-enable mask, and a third accepts a write-one-to-clear mask. When a memory-bus error is first latched, the faulting 64-bit bus address is captured. It is held for inspection in two 32-bit words until the error cause is cleared, so a burst of later errors cannot overwrite the address of the first one.

Top module: `irq_agg_regs`

## Requirements
- R1: After reset the status bits, the enable bits and the captured error address are all zero, and `irq_out` is low.
- R2: The register word index is `reg_addr[ADDR_W-1:2]`, and the two low address bits are ignored. Index 0 reads the captured address bits 31:0, index 1 reads bits 63:32, index 3 reads the status, index 5 reads the enable mask, and index 7 and every other index read zero. Writes to indices 0, 1 and 3 change nothing.
- R3: Status bit 0 is the device interrupt and status bit 1 is the memory-bus error. A one-cycle pulse on `dev_evt` or `mem_err_evt` sets its bit, which reads 1 from the next cycle on and stays set until it is cleared.
- R4: Writing to index 7 clears, from the next cycle on, each status bit whose write-data bit (bit 0 or bit 1) is 1. Status bits written with 0 are untouched, and write-data bits above bit 1 are ignored, so writing 0x03 clears both bits.
- R5: Writing to index 5 sets, from the next cycle on, each enable bit whose write-data bit (bit 0 or bit 1) is 1. Enable bits written with 0 keep their value, and only reset clears an enable bit, so writing 0x03 enables both causes.
- R6: `irq_out` is high exactly when some status bit and its enable bit are both 1. It is derived without a further register, so it rises in the cycle after the event that sets an enabled bit.
- R7: The error address is loaded from `mem_err_addr` when a memory-bus error event arrives while status bit 1 is 0, or while status bit 1 is being cleared in that same cycle. At all other times it holds its value.
- R8: When an event and a clear of the same status bit occur in the same cycle, the event wins and the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (8) | Register byte address |
| reg_wdata | input | DATA_W (32) | Register write data |
| reg_rdata | output | DATA_W (32) | Read data for `reg_addr`, combinational |
| dev_evt | input | 1 | Device interrupt event pulse |
| mem_err_evt | input | 1 | DMA memory-bus error event pulse |
| mem_err_addr | input | ERR_ADDR_W (64) | Bus address of the faulting access, valid with `mem_err_evt` |
| irq_out | output | 1 | Level interrupt to the host |

## Verification
Every event and register write takes effect at the first rising edge that samples it. The status, enable mask, captured address and `irq_out` are therefore all due one cycle later, and read data follows `reg_addr` within the same cycle. The bench drives each stimulus at a falling edge and lets one rising edge pass. It then drops the strobes and, before the next falling edge, steps `reg_addr` through the readable words, comparing each against a bench model that was advanced at that same edge. Directed cases cover a clear that coincides with an event, a second error arriving while the first is pending, and an error that coincides with its own clear. Seeded random traffic covers the remaining mixes of events and writes.

// File: rtl/irq_agg_pkg.sv
`timescale 1ns/1ps
package irq_agg_pkg;
   // word indices of the register map (byte offset = index * 4)
   localparam int unsigned IDX_ADDR_LO = 0;
   localparam int unsigned IDX_ADDR_HI = 1;
   localparam int unsigned IDX_STATUS  = 3;
   localparam int unsigned IDX_ENSET   = 5;
   localparam int unsigned IDX_CLR     = 7;

   // status bit positions
   localparam int unsigned SRC_DEV     = 0;
   localparam int unsigned SRC_MEMERR  = 1;
   localparam int unsigned NUM_SRC     = 2;

   typedef struct packed {
      logic wr_enset;
      logic wr_clr;
   } wr_decode_t;
endpackage

// File: rtl/irq_src_latch.sv
`timescale 1ns/1ps
module irq_src_latch #(
   parameter int unsigned N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] evt,
   input  logic [N-1:0] clr,
   output logic [N-1:0] sts
);
   for (genvar i = 0; i < N; i++) begin : g_bit
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      q <= 1'b0;
         else if (evt[i]) q <= 1'b1;   // event has priority over clear
         else if (clr[i]) q <= 1'b0;
      end
      assign sts[i] = q;

      // R3
      evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
         evt[i] |=> sts[i]);
      // R4
      clr_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (clr[i] && !evt[i]) |=> !sts[i]);
      // R8
      evt_beats_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (clr[i] && evt[i]) |=> sts[i]);
      // R3
      hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!clr[i] && !evt[i]) |=> $stable(sts[i]));
   end
endmodule

// File: rtl/irq_en_mask.sv
`timescale 1ns/1ps
module irq_en_mask #(
   parameter int unsigned N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         set_wr,
   input  logic [N-1:0] set_bits,
   output logic [N-1:0] en
);
   logic [N-1:0] en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      en_q <= '0;
      else if (set_wr) en_q <= en_q | set_bits;
   end
   assign en = en_q;

   for (genvar i = 0; i < N; i++) begin : g_chk
      // R5
      en_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
         en[i] |=> en[i]);
      // R5
      en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (set_wr && set_bits[i]) |=> en[i]);
   end
endmodule

// File: rtl/irq_err_capture.sv
`timescale 1ns/1ps
module irq_err_capture #(
   parameter int unsigned AW = 64
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          err_evt,
   input  logic [AW-1:0] err_addr_in,
   input  logic          err_pending,
   input  logic          err_clr,
   output logic [AW-1:0] err_addr
);
   logic          take;
   logic [AW-1:0] addr_q;

   assign take = err_evt && (!err_pending || err_clr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    addr_q <= '0;
      else if (take) addr_q <= err_addr_in;
   end
   assign err_addr = addr_q;

   // R7
   err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (err_pending && !err_clr) |=> $stable(err_addr));
   // R7
   err_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (err_evt && !err_pending) |=> (err_addr == $past(err_addr_in)));
endmodule

// File: rtl/irq_agg_regs.sv
`timescale 1ns/1ps
module irq_agg_regs
   import irq_agg_pkg::*;
#(
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned ERR_ADDR_W = 64
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  reg_wr,
   input  logic [ADDR_W-1:0]     reg_addr,
   input  logic [DATA_W-1:0]     reg_wdata,
   output logic [DATA_W-1:0]     reg_rdata,
   input  logic                  dev_evt,
   input  logic                  mem_err_evt,
   input  logic [ERR_ADDR_W-1:0] mem_err_addr,
   output logic                  irq_out
);
   localparam int unsigned IDX_W = ADDR_W - 2;

   // elaboration-time parameter checks
   if (ADDR_W < 5) begin : g_bad_aw
      $error("ADDR_W must cover word index 7");
   end
   if (ERR_ADDR_W != 2 * DATA_W) begin : g_bad_ew
      $error("ERR_ADDR_W must be two data words");
   end
   if (DATA_W < NUM_SRC) begin : g_bad_dw
      $error("DATA_W too narrow for status");
   end

   logic [IDX_W-1:0]      idx;
   wr_decode_t            wdec;
   logic [NUM_SRC-1:0]    evt, clr, sts, en;
   logic [ERR_ADDR_W-1:0] cap_addr;

   assign idx          = reg_addr[ADDR_W-1:2];
   assign wdec.wr_enset = reg_wr && (idx == IDX_W'(IDX_ENSET));
   assign wdec.wr_clr   = reg_wr && (idx == IDX_W'(IDX_CLR));

   assign evt[SRC_DEV]    = dev_evt;
   assign evt[SRC_MEMERR] = mem_err_evt;
   assign clr = wdec.wr_clr ? reg_wdata[NUM_SRC-1:0] : '0;

   irq_src_latch #(.N(NUM_SRC)) u_src (
      .clk   (clk),
      .rst_n (rst_n),
      .evt   (evt),
      .clr   (clr),
      .sts   (sts)
   );

   irq_en_mask #(.N(NUM_SRC)) u_en (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_wr   (wdec.wr_enset),
      .set_bits (reg_wdata[NUM_SRC-1:0]),
      .en       (en)
   );

   irq_err_capture #(.AW(ERR_ADDR_W)) u_cap (
      .clk         (clk),
      .rst_n       (rst_n),
      .err_evt     (mem_err_evt),
      .err_addr_in (mem_err_addr),
      .err_pending (sts[SRC_MEMERR]),
      .err_clr     (clr[SRC_MEMERR]),
      .err_addr    (cap_addr)
   );

   // read mux
   always_comb begin
      reg_rdata = '0;
      if (idx == IDX_W'(IDX_ADDR_LO))      reg_rdata = cap_addr[DATA_W-1:0];
      else if (idx == IDX_W'(IDX_ADDR_HI)) reg_rdata = cap_addr[ERR_ADDR_W-1:DATA_W];
      else if (idx == IDX_W'(IDX_STATUS))  reg_rdata[NUM_SRC-1:0] = sts;
      else if (idx == IDX_W'(IDX_ENSET))   reg_rdata[NUM_SRC-1:0] = en;
   end

   assign irq_out = |(sts & en);

   // R6
   irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sts == '0 || en == '0) |-> !irq_out);
   // R6
   irq_dev_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_evt && en[SRC_DEV]) |=> irq_out);
endmodule

// File: tb/sim_irq_agg_regs.sv
`timescale 1ns/1ps
module sim_irq_agg_regs;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        dev_evt = 1'b0;
   logic        mem_err_evt = 1'b0;
   logic [63:0] mem_err_addr = '0;
   logic        irq_out;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   // model state
   logic [1:0]  m_sts = '0;
   logic [1:0]  m_en = '0;
   logic [63:0] m_addr = '0;

   always #4 clk = ~clk;   // 125 MHz

   irq_agg_regs u0 (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dev_evt(dev_evt),
      .mem_err_evt(mem_err_evt), .mem_err_addr(mem_err_addr), .irq_out(irq_out)
   );

   function automatic logic [1:0] f_sts(logic [1:0] s, logic [1:0] e,
                                        logic w, logic [7:0] a, logic [31:0] d);
      logic [1:0] c;
      c = (w && a[7:2] == 6'd7) ? d[1:0] : 2'b00;
      return e | (s & ~c);
   endfunction

   function automatic logic [1:0] f_en(logic [1:0] en, logic w, logic [7:0] a,
                                       logic [31:0] d);
      return (w && a[7:2] == 6'd5) ? (en | d[1:0]) : en;
   endfunction

   function automatic logic [63:0] f_addr(logic [63:0] cur, logic [1:0] s,
                                          logic me, logic [63:0] ain, logic w,
                                          logic [7:0] a, logic [31:0] d);
      logic clr1;
      clr1 = w && a[7:2] == 6'd7 && d[1];
      return (me && (!s[1] || clr1)) ? ain : cur;
   endfunction

   task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic rd(logic [7:0] a, output logic [31:0] v);
      reg_addr = a;
      #0.5;
      v = reg_rdata;
   endtask

   // read back all visible state and compare with the model
   task automatic check_all(string tag);
      logic [31:0] v;
      rd(8'h0C, v); chk({tag, " R3 status"}, 64'(v), 64'(m_sts));
      rd(8'h14, v); chk({tag, " R5 enable"}, 64'(v), 64'(m_en));
      rd(8'h00, v); chk({tag, " R7 addr lo"}, 64'(v), 64'(m_addr[31:0]));
      rd(8'h04, v); chk({tag, " R7 addr hi"}, 64'(v), 64'(m_addr[63:32]));
      chk({tag, " R6 irq"}, 64'(irq_out), 64'(|(m_sts & m_en)));
   endtask

   // one active cycle, then checks before the next falling edge
   task automatic cyc(logic de, logic me, logic [63:0] ain, logic w,
                      logic [7:0] a, logic [31:0] d, string tag);
      @(negedge clk);
      dev_evt = de; mem_err_evt = me; mem_err_addr = ain;
      reg_wr = w; reg_addr = a; reg_wdata = d;
      @(posedge clk);
      m_addr = f_addr(m_addr, m_sts, me, ain, w, a, d);
      m_sts  = f_sts(m_sts, {me, de}, w, a, d);
      m_en   = f_en(m_en, w, a, d);
      #1;
      dev_evt = 1'b0; mem_err_evt = 1'b0; reg_wr = 1'b0;
      check_all(tag);
   endtask

   initial begin
      #(64'd8 * 200000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      #1;
      // R1: reset state
      check_all("R1");
      rst_n = 1'b1;

      // R3 / R6: device event latched but not enabled -> no irq
      cyc(1, 0, '0, 0, 8'h00, '0, "R3 dev");
      chk("R6 masked irq", 64'(irq_out), 64'd0);
      // R5: enable both with 0x03
      cyc(0, 0, '0, 1, 8'h14, 32'h3, "R5 set");
      chk("R6 irq on enable", 64'(irq_out), 64'd1);
      // R5: writing 0 leaves enable alone
      cyc(0, 0, '0, 1, 8'h14, 32'h0, "R5 zero");
      // R4: clear bit0 only
      cyc(0, 0, '0, 1, 8'h1C, 32'h1, "R4 clr0");
      chk("R4 status zero", 64'(m_sts), 64'd0);
      // R7: first error captured
      cyc(0, 1, 64'hA5A5_0001_DEAD_BEE0, 0, 8'h00, '0, "R7 first");
      // R7: second error while pending is ignored
      cyc(0, 1, 64'h1111_2222_3333_4444, 0, 8'h00, '0, "R7 second");
      rd(8'h00, v); chk("R7 keep first lo", 64'(v), 64'hDEAD_BEE0);
      // R2: writes to status and address words change nothing
      cyc(0, 0, '0, 1, 8'h0C, 32'h0, "R2 wr status");
      cyc(0, 0, '0, 1, 8'h00, 32'hFFFF_FFFF, "R2 wr addr");
      // R2: index 7, unused index, misaligned read
      rd(8'h1C, v); chk("R2 clear word reads 0", 64'(v), 64'd0);
      rd(8'h08, v); chk("R2 unused reads 0", 64'(v), 64'd0);
      rd(8'h0F, v); chk("R2 low bits ignored", 64'(v), 64'd2);
      // R4: upper data bits ignored
      cyc(0, 0, '0, 1, 8'h1C, 32'hFFFF_FFFC, "R4 upper");
      chk("R4 upper ignored", 64'(m_sts), 64'd2);
      // R8: error and clear together, new address taken (R7)
      cyc(0, 1, 64'h0BAD_F00D_0000_1234, 1, 8'h1C, 32'h3, "R8 same");
      chk("R8 event wins", 64'(m_sts), 64'd2);
      rd(8'h04, v); chk("R7 recapture hi", 64'(v), 64'h0BAD_F00D);
      // R8: device event with clear of bit0
      cyc(1, 0, '0, 1, 8'h1C, 32'h1, "R8 dev");
      // clear all
      cyc(0, 0, '0, 1, 8'h1C, 32'h3, "R4 both");
      chk("R6 irq low", 64'(irq_out), 64'd0);

      // seeded random traffic
      for (int k = 0; k < 400; k++) begin
         logic [2:0] pick;
         logic [7:0] a;
         pick = 3'($urandom % 5);
         case (pick)
            3'd0:    a = 8'h14;
            3'd1:    a = 8'h1C;
            3'd2:    a = 8'h0C;
            3'd3:    a = 8'h00;
            default: a = 8'h1D;
         endcase
         cyc(1'($urandom), 1'($urandom), {$urandom, $urandom},
             ($urandom % 3) != 0, a, $urandom, "rnd");
      end

      // R1: reset mid-run clears state
      @(negedge clk);
      rst_n = 1'b0;
      m_sts = '0; m_en = '0; m_addr = '0;
      #1;
      check_all("R1 rerun");

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule